// File: doc/BRIEF.md
# Interrupt Aggregator with Two-Level Enable

The block gathers level-sensitive interrupt requests from six on-chip sources and presents them to the host as one registered level line. The sources are two I2C masters, one SPI master, two DMA channels and a common-interface controller. A host driver reads a per-source pending register to find out which requests are high. It picks the sources allowed to interrupt through a mask that has separate set and clear write addresses. A single global enable bit then gates the combined request onto the host line.

A global status bit is also readable. It reports whether any unmasked source is pending, whatever the global enable is. A handler can therefore clear the global enable on entry, which drops the host line at once, and still learn that work is waiting. Each source clears its own request inside its own logic, so this block only observes the request levels.

Register access is a simple synchronous port. Each access is one cycle, selected by byte address. Read data is registered and appears in the cycle after the read strobe.

Top module: `irqHub`

## Requirements
- R1: After reset the mask is all zeros, the global enable is 0, `hostIrq` is 0 and `regRdData` is 0.
- R2: A read of address 0x10 returns the raw request levels: bit 0 I2C0, bit 1 I2C1, bit 2 SPI, bit 3 DMA0, bit 4 DMA1, bit 5 common interface. This holds whatever the mask is. Bits 6 to 31 read as 0, and the read changes no state.
- R3: A write to address 0x12 sets every mask bit whose data bit (0 to 5) is 1 and leaves every other mask bit unchanged. Reads of 0x12 or 0x14 return the mask in bits 0 to 5, with zeros above.
- R4: A write to address 0x14 clears every mask bit whose data bit is 1 and leaves the rest unchanged. Writing 0xFFFF there clears the whole mask.
- R5: The global enable is bit 7 of address 0x50. A write stores data bit 7 only. A read returns 0x80 when enabled and 0 otherwise.
- R6: A read of address 0x40 returns 0x80 when any source is both requesting and unmasked, and 0 otherwise. The global enable has no effect on this value.
- R7: `hostIrq` is registered. After each clock edge it equals enable AND the OR over (request AND mask), where the request is the one sampled at that edge and the enable and mask are the values that include any write made at that same edge.
- R8: Writing 0 to address 0x50 drives `hostIrq` low after that same edge, even while unmasked sources stay pending. Writing 0x80 again raises it after the edge if an unmasked source is still pending.
- R9: A write to any other address changes neither the mask nor the enable. A read of any other address returns 0.
- R10: `regRdData` loads only on a clock edge where `regRdEn` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 8 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe, one cycle per read |
| regRdData | output | 32 | Registered read data, valid the cycle after `regRdEn` |
| srcReq | input | 6 | Request levels from the six sources |
| hostIrq | output | 1 | Level interrupt toward the host |

## Verification
In one cycle, a register write that changes the enable or the mask can coincide with a source request rising. The bench provokes this by changing `srcReq` in the same cycle as a write of 0 to the enable, a mask clear or a mask set. It then judges `hostIrq` after that edge against the post-write enable and mask: low for the first two cases and high for the third. Beyond these cases, every mask value is swept against every request pattern with the enable both off and on. Each point checks `hostIrq` and the global status read against the arithmetic AND/OR of the two vectors.

// File: rtl/irqHubPkg.sv
package irqHubPkg;

  // Strobes passed from address decode to the datapath.
  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic enWr;
    logic rdLoad;
  } hubCtlT;

  // Read source selection.
  typedef enum logic [2:0] {
    SEL_ZERO  = 3'd0,
    SEL_SRC   = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_EN    = 3'd3,
    SEL_GSTAT = 3'd4
  } rdSelT;

endpackage

// File: rtl/irqHubCtrl.sv
module irqHubCtrl
  import irqHubPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SRC_ADDR   = 'h10,
  parameter logic [ADDR_W-1:0] SET_ADDR   = 'h12,
  parameter logic [ADDR_W-1:0] CLR_ADDR   = 'h14,
  parameter logic [ADDR_W-1:0] GSTAT_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] GEN_ADDR   = 'h50
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output hubCtlT            ctl,
  output rdSelT             rdSel
);

  logic hitSet, hitClr, hitGen;

  assign hitSet = (regAddr == SET_ADDR);
  assign hitClr = (regAddr == CLR_ADDR);
  assign hitGen = (regAddr == GEN_ADDR);

  always_comb begin
    ctl.maskSet = regWrEn && hitSet;
    ctl.maskClr = regWrEn && hitClr;
    ctl.enWr    = regWrEn && hitGen;
    ctl.rdLoad  = regRdEn;
  end

  always_comb begin
    if (regAddr == SRC_ADDR)        rdSel = SEL_SRC;
    else if (hitSet || hitClr)      rdSel = SEL_MASK;
    else if (hitGen)                rdSel = SEL_EN;
    else if (regAddr == GSTAT_ADDR) rdSel = SEL_GSTAT;
    else                            rdSel = SEL_ZERO;
  end

endmodule

// File: rtl/irqHubDatapath.sv
module irqHubDatapath
  import irqHubPkg::*;
#(
  parameter int NUM_SRC   = 6,
  parameter int DATA_W    = 32,
  parameter int EN_BIT    = 7,
  parameter int GSTAT_BIT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  hubCtlT             ctl,
  input  rdSelT              rdSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic [NUM_SRC-1:0] maskVal,
  output logic [DATA_W-1:0]  rdData,
  output logic               hostIrq
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] maskQ, maskNext;
  logic               enQ, enNext;
  logic               pendAny;
  logic [DATA_W-1:0]  rdNext;
  logic               unusedWr;

  assign unusedWr = ^wrData;

  // Per-bit mask update: a set strobe wins, then a clear strobe, else hold.
  for (genvar i = 0; i < NUM_SRC; i++) begin : gMask
    always_comb begin
      if (ctl.maskSet && wrData[i])      maskNext[i] = 1'b1;
      else if (ctl.maskClr && wrData[i]) maskNext[i] = 1'b0;
      else                               maskNext[i] = maskQ[i];
    end
  end

  assign enNext  = ctl.enWr ? wrData[EN_BIT] : enQ;
  assign pendAny = |(srcReq & maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      enQ     <= 1'b0;
      hostIrq <= 1'b0;
    end else begin
      maskQ   <= maskNext;
      enQ     <= enNext;
      hostIrq <= enNext && (|(srcReq & maskNext));
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (rdSel)
      SEL_SRC:   rdNext = {{PAD_W{1'b0}}, srcReq};
      SEL_MASK:  rdNext = {{PAD_W{1'b0}}, maskQ};
      SEL_EN:    rdNext[EN_BIT] = enQ;
      SEL_GSTAT: rdNext[GSTAT_BIT] = pendAny;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (ctl.rdLoad) rdData <= rdNext;
  end

  assign maskVal = maskQ;

endmodule

// File: rtl/irqHub.sv
module irqHub
  import irqHubPkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] SRC_ADDR   = 'h10,
  parameter logic [ADDR_W-1:0] SET_ADDR   = 'h12,
  parameter logic [ADDR_W-1:0] CLR_ADDR   = 'h14,
  parameter logic [ADDR_W-1:0] GSTAT_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] GEN_ADDR   = 'h50,
  parameter int EN_BIT    = 7,
  parameter int GSTAT_BIT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               regRdEn,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic               hostIrq
);

  hubCtlT             ctl;
  rdSelT              rdSel;
  logic [NUM_SRC-1:0] maskVal;

  irqHubCtrl #(
    .ADDR_W(ADDR_W), .SRC_ADDR(SRC_ADDR), .SET_ADDR(SET_ADDR),
    .CLR_ADDR(CLR_ADDR), .GSTAT_ADDR(GSTAT_ADDR), .GEN_ADDR(GEN_ADDR)
  ) uCtrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .ctl(ctl), .rdSel(rdSel)
  );

  irqHubDatapath #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .EN_BIT(EN_BIT), .GSTAT_BIT(GSTAT_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdSel(rdSel), .wrData(regWrData),
    .srcReq(srcReq), .maskVal(maskVal), .rdData(regRdData), .hostIrq(hostIrq)
  );

endmodule

// File: rtl/irqHubChecker.sv
module irqHubChecker #(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] SRC_ADDR   = 'h10,
  parameter logic [ADDR_W-1:0] SET_ADDR   = 'h12,
  parameter logic [ADDR_W-1:0] CLR_ADDR   = 'h14,
  parameter logic [ADDR_W-1:0] GSTAT_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] GEN_ADDR   = 'h50,
  parameter int EN_BIT    = 7,
  parameter int GSTAT_BIT = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [DATA_W-1:0]  regWrData,
  input logic               regRdEn,
  input logic [DATA_W-1:0]  regRdData,
  input logic [NUM_SRC-1:0] srcReq,
  input logic [NUM_SRC-1:0] maskVal,
  input logic               hostIrq
);

  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!hostIrq && maskVal == '0);
    end
  end

  assert_raw_status_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == SRC_ADDR) |=>
      regRdData == {{(DATA_W-NUM_SRC){1'b0}}, $past(srcReq)});

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == SET_ADDR) |=>
      maskVal == ($past(maskVal) | $past(regWrData[NUM_SRC-1:0])));

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == CLR_ADDR && (&regWrData[NUM_SRC-1:0])) |=>
      (maskVal == '0 && !hostIrq));

  assert_gstat_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == GSTAT_ADDR) |=>
      regRdData[GSTAT_BIT] == $past(|(srcReq & maskVal)));

  assert_irq_needs_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> $past(|srcReq));

  assert_disable_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == GEN_ADDR && !regWrData[EN_BIT]) |=> !hostIrq);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData));

endmodule

bind irqHub irqHubChecker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .SRC_ADDR(SRC_ADDR), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR),
  .GSTAT_ADDR(GSTAT_ADDR), .GEN_ADDR(GEN_ADDR),
  .EN_BIT(EN_BIT), .GSTAT_BIT(GSTAT_BIT)
) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
  .srcReq(srcReq), .maskVal(maskVal), .hostIrq(hostIrq)
);

// File: tb/sim_irqHub.sv
`timescale 1ns/1ps
module sim_irqHub;

  localparam logic [7:0] A_SRC = 8'h10, A_SET = 8'h12, A_CLR = 8'h14;
  localparam logic [7:0] A_GST = 8'h40, A_GEN = 8'h50, A_BAD = 8'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic [5:0]  srcReq = '0;
  logic        hostIrq;

  int nChecks = 0;
  int nBad = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;

  irqHub u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .srcReq(srcReq), .hostIrq(hostIrq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    v = regRdData;
  endtask

  logic [31:0] v, v2;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hostIrq in reset", {31'b0, hostIrq}, 32'h0);
    chk("R1 rdData in reset", regRdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    rd(A_SET, v); chk("R1 mask after reset", v, 32'h0);
    rd(A_GEN, v); chk("R1 enable after reset", v, 32'h0);

    // R2: raw levels, mask zero, no side effect
    srcReq = 6'h2d; @(negedge clk);
    rd(A_SRC, v);  chk("R2 raw status", v, 32'h2d);
    rd(A_SRC, v2); chk("R2 repeat read", v2, 32'h2d);
    chk("R2 no irq when masked", {31'b0, hostIrq}, 32'h0);

    // R3: set merges
    wr(A_SET, 32'h0000_0005);
    wr(A_SET, 32'h0000_0012);
    rd(A_SET, v); chk("R3 set merge", v, 32'h17);
    rd(A_CLR, v); chk("R3 read via clear addr", v, 32'h17);
    // R4: partial clear, then clear all
    wr(A_CLR, 32'h0000_0003);
    rd(A_SET, v); chk("R4 partial clear", v, 32'h14);
    wr(A_CLR, 32'h0000_FFFF);
    rd(A_SET, v); chk("R4 clear all", v, 32'h0);

    // R5: enable bit only
    wr(A_GEN, 32'hFFFF_FF7F);
    rd(A_GEN, v); chk("R5 non-enable bits ignored", v, 32'h0);
    wr(A_GEN, 32'h0000_0080);
    rd(A_GEN, v); chk("R5 enable readback", v, 32'h80);
    wr(A_GEN, 32'h0);

    // R9: unknown address
    wr(A_SET, 32'h09);
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_SET, v); chk("R9 mask untouched", v, 32'h09);
    rd(A_GEN, v); chk("R9 enable untouched", v, 32'h0);
    rd(A_BAD, v); chk("R9 unknown reads zero", v, 32'h0);

    // R10: hold without read strobe
    rd(A_SRC, v);
    srcReq = 6'h12; @(negedge clk); @(negedge clk);
    chk("R10 rdData holds", regRdData, v);

    // R6/R7: exhaustive sweep over enable, mask and request
    for (int e = 0; e < 2; e++) begin
      wr(A_GEN, e ? 32'h80 : 32'h0);
      for (int m = 0; m < 64; m++) begin
        wr(A_CLR, 32'hFFFF);
        wr(A_SET, m);
        for (int r = 0; r < 64; r++) begin
          logic pend;
          pend = |(6'(r) & 6'(m));
          srcReq = 6'(r);
          @(negedge clk);
          chk($sformatf("R7 hostIrq e=%0d m=%0h r=%0h", e, m, r),
              {31'b0, hostIrq}, {31'b0, pend && (e == 1)});
          rd(A_GST, v);
          chk($sformatf("R6 gstat e=%0d m=%0h r=%0h", e, m, r),
              v, pend ? 32'h80 : 32'h0);
        end
      end
    end

    // Same-cycle cases: enable write, mask clear, mask set with request rising
    wr(A_CLR, 32'hFFFF); wr(A_SET, 32'h3F); srcReq = '0; wr(A_GEN, 32'h80);
    chk("R8 idle low", {31'b0, hostIrq}, 32'h0);
    srcReq = 6'h01; wr(A_GEN, 32'h0);
    chk("R8 disable same cycle as request", {31'b0, hostIrq}, 32'h0);
    @(negedge clk);
    chk("R8 stays low while pending", {31'b0, hostIrq}, 32'h0);
    rd(A_GST, v); chk("R6 gstat while disabled", v, 32'h80);
    wr(A_GEN, 32'h80);
    chk("R8 re-enable raises", {31'b0, hostIrq}, 32'h1);
    srcReq = 6'h00; @(negedge clk);
    srcReq = 6'h04; wr(A_CLR, 32'h04);
    chk("R7 clear same cycle as request", {31'b0, hostIrq}, 32'h0);
    srcReq = 6'h24; wr(A_SET, 32'h04);
    chk("R7 set same cycle as request", {31'b0, hostIrq}, 32'h1);
    wr(A_CLR, 32'hFFFF);
    chk("R4 clear all drops line", {31'b0, hostIrq}, 32'h0);

    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      nChecks++; nBad++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule